// File: doc/BRIEF.md
# Shadow boot ROM overlay

This block places a boot ROM over the bottom of a CPU's RAM address space so that a processor coming out of reset fetches its start-up code from ROM. It sits between the CPU memory strobe and two internal arrays, one ROM and one RAM. The ROM image is supplied as a parameter array. The ROM is smaller than the window, so its image repeats across the window.

Writes always land in the RAM, including writes to addresses that the ROM currently covers. Boot code can therefore copy itself, or anything else, into the RAM underneath. It then drops the overlay and keeps running from RAM.

The overlay is switched from the parallel printer port. Each byte the CPU writes to that port is latched for the printer with a pending flag, and its bit 0 also decides whether the ROM stays mapped. The port also holds one byte received from the printer side, with a ready flag that a port read clears. Two configuration inputs can force the overlay on or off.

Top module: `shadow_rom_overlay`

## Requirements
- R1: After reset the overlay is enabled, `prn_tx_pend_o` is 0, `prn_rx_rdy_o` is 0 and both read data outputs are 0.
- R2: Take a memory read with the overlay enabled and an address whose bits above WIN_W are all 0 (the window is 2**WIN_W bytes from address 0, 8192 by default). `mem_rdata_o` shows ROM_IMAGE[addr mod 2**ROM_W] from the cycle after the request.
- R3: Take a memory read at an address outside the window, or at any address while the overlay is disabled. `mem_rdata_o` shows the RAM byte at addr mod 2**RAM_W from the cycle after the request.
- R4: A memory write always stores into RAM, even inside the window while the overlay is enabled. Once the overlay is disabled, that address reads back the written byte.
- R5: A printer port write with data bit 0 = 1 disables the overlay, and with bit 0 = 0 enables it. The change applies to memory reads from the next cycle on.
- R6: A printer port write latches the byte on `prn_tx_data_o` and sets `prn_tx_pend_o` in the next cycle. A write while the flag is still pending replaces the latched byte.
- R7: `prn_tx_ack_i` clears `prn_tx_pend_o` in the next cycle. If a port write comes in the same cycle as the ack, the write wins and the flag stays set.
- R8: `prn_rx_stb_i` latches `prn_rx_data_i` and sets `prn_rx_rdy_o`. A printer port read puts the latched byte on `io_rdata_o` in the next cycle and clears `prn_rx_rdy_o`. If a strobe comes in the same cycle as the read, `prn_rx_rdy_o` stays set.
- R9: `force_off_i` disables the overlay and `force_on_i` enables it, in the next cycle. Either one overrides a port write in the same cycle, and `force_off_i` wins over `force_on_i`.
- R10: `mem_rdata_o` holds its value in every cycle without a memory read, including cycles with a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_i | input | 1 | Memory access strobe |
| mem_we_i | input | 1 | 1 = write, 0 = read |
| mem_addr_i | input | ADDR_W | Memory address |
| mem_wdata_i | input | 8 | Memory write data |
| mem_rdata_o | output | 8 | Registered memory read data |
| force_on_i | input | 1 | Force the overlay on |
| force_off_i | input | 1 | Force the overlay off (wins over force on) |
| io_wr_i | input | 1 | Printer port write strobe |
| io_rd_i | input | 1 | Printer port read strobe |
| io_wdata_i | input | 8 | Printer port write data |
| io_rdata_o | output | 8 | Registered printer port read data |
| prn_tx_data_o | output | 8 | Byte latched for the printer |
| prn_tx_pend_o | output | 1 | Printer byte waiting to be taken |
| prn_tx_ack_i | input | 1 | Printer has taken the byte |
| prn_rx_data_i | input | 8 | Byte from the printer side |
| prn_rx_stb_i | input | 1 | Strobe that captures `prn_rx_data_i` |
| prn_rx_rdy_o | output | 1 | Received byte not yet read |

## Verification
The assertions check, on every cycle:
- the flag rules, that is how the transmit pending flag is set and cleared and how the receive ready flag is set and cleared;
- that a port write picks the overlay state, and that a force overrides it;
- that read data holds when there is no memory read.

Only the bench's scenarios can show which array a read actually returns. These scenarios sweep every address of a small configuration with the overlay on and off, check that RAM hidden under the ROM keeps what was written there, and check the same-cycle cases of write with ack, read with strobe, and the two forces together.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ovl_ctrl.sv
module ovl_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic port_wr_i,
  input  logic port_bit_i,
  input  logic force_on_i,
  input  logic force_off_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= 1'b1;
    else if (force_off_i) en_q <= 1'b0;
    else if (force_on_i)  en_q <= 1'b1;
    else if (port_wr_i)   en_q <= ~port_bit_i;
  end

  assign en_o = en_q;

  AST_FORCE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> !en_o); // R9
  AST_FORCE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_on_i && !force_off_i) |=> en_o); // R9
  AST_PORT_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr_i && !force_on_i && !force_off_i) |=> (en_o == !$past(port_bit_i))); // R5
endmodule

// File: rtl/ovl_mem.sv
module ovl_mem #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 13,
  parameter int ROM_W  = 11,
  parameter int RAM_W  = 12,
  parameter ovl_pkg::byte_t ROM_IMAGE [2**ROM_W] = '{default: 8'h00}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  ovl_pkg::byte_t    wdata_i,
  input  logic              en_i,
  output ovl_pkg::byte_t    rdata_o
);
  localparam int RAM_DEPTH = 2**RAM_W;

  ovl_pkg::byte_t ram_q [RAM_DEPTH];
  ovl_pkg::byte_t rdata_q;
  logic           in_win;
  logic           rd_en;
  logic           unused_addr;

  generate
    if (WIN_W >= ADDR_W) begin : g_full_win
      assign in_win = 1'b1;
    end else begin : g_part_win
      assign in_win = ~|addr_i[ADDR_W-1:WIN_W];
    end
  endgenerate

  assign unused_addr = ^addr_i;
  assign rd_en = req_i && !we_i;

  always_ff @(posedge clk_i) begin
    if (req_i && we_i) ram_q[addr_i[RAM_W-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_en)
      rdata_q <= (en_i && in_win) ? ROM_IMAGE[addr_i[ROM_W-1:0]]
                                  : ram_q[addr_i[RAM_W-1:0]];
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata_o)); // R10

  initial begin
    assert (ROM_W <= WIN_W && RAM_W <= ADDR_W && WIN_W <= ADDR_W);
  end
endmodule

// File: rtl/prn_port.sv
module prn_port (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           rd_i,
  input  ovl_pkg::byte_t wdata_i,
  output ovl_pkg::byte_t rdata_o,
  output ovl_pkg::byte_t tx_data_o,
  output logic           tx_pend_o,
  input  logic           tx_ack_i,
  input  ovl_pkg::byte_t rx_data_i,
  input  logic           rx_stb_i,
  output logic           rx_rdy_o
);
  ovl_pkg::byte_t tx_q, rx_q, rd_q;
  logic           pend_q, rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      pend_q <= 1'b0;
    end else if (wr_i) begin
      tx_q   <= wdata_i;
      pend_q <= 1'b1;
    end else if (tx_ack_i) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      rdy_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (rd_i) rd_q <= rx_q;
      if (rx_stb_i) begin
        rx_q  <= rx_data_i;
        rdy_q <= 1'b1;
      end else if (rd_i) begin
        rdy_q <= 1'b0;
      end
    end
  end

  assign tx_data_o = tx_q;
  assign tx_pend_o = pend_q;
  assign rx_rdy_o  = rdy_q;
  assign rdata_o   = rd_q;

  AST_TX_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (tx_pend_o && tx_data_o == $past(wdata_i))); // R6
  AST_TX_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ack_i && !wr_i) |=> !tx_pend_o); // R7
  AST_RX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stb_i |=> rx_rdy_o); // R8
  AST_RX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rx_stb_i) |=> !rx_rdy_o); // R8
endmodule

// File: rtl/shadow_rom_overlay.sv
module shadow_rom_overlay #(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 13,
  parameter int ROM_W  = 11,
  parameter int RAM_W  = 12,
  parameter ovl_pkg::byte_t ROM_IMAGE [2**ROM_W] = '{default: 8'h00}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [7:0]        mem_wdata_i,
  output logic [7:0]        mem_rdata_o,
  input  logic              force_on_i,
  input  logic              force_off_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic [7:0]        prn_tx_data_o,
  output logic              prn_tx_pend_o,
  input  logic              prn_tx_ack_i,
  input  logic [7:0]        prn_rx_data_i,
  input  logic              prn_rx_stb_i,
  output logic              prn_rx_rdy_o
);
  logic ovl_en;

  ovl_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .port_wr_i   (io_wr_i),
    .port_bit_i  (io_wdata_i[0]),
    .force_on_i  (force_on_i),
    .force_off_i (force_off_i),
    .en_o        (ovl_en)
  );

  ovl_mem #(
    .ADDR_W    (ADDR_W),
    .WIN_W     (WIN_W),
    .ROM_W     (ROM_W),
    .RAM_W     (RAM_W),
    .ROM_IMAGE (ROM_IMAGE)
  ) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (mem_req_i),
    .we_i    (mem_we_i),
    .addr_i  (mem_addr_i),
    .wdata_i (mem_wdata_i),
    .en_i    (ovl_en),
    .rdata_o (mem_rdata_o)
  );

  prn_port u_prn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (io_wr_i),
    .rd_i      (io_rd_i),
    .wdata_i   (io_wdata_i),
    .rdata_o   (io_rdata_o),
    .tx_data_o (prn_tx_data_o),
    .tx_pend_o (prn_tx_pend_o),
    .tx_ack_i  (prn_tx_ack_i),
    .rx_data_i (prn_rx_data_i),
    .rx_stb_i  (prn_rx_stb_i),
    .rx_rdy_o  (prn_rx_rdy_o)
  );
endmodule

// File: tb/sim_shadow_rom_overlay.sv
module sim_shadow_rom_overlay;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WW = 4;
  localparam int RW = 3;
  localparam int MW = 6;
  localparam logic [7:0] IMG [2**RW] = '{8'hC3, 8'h11, 8'h5A, 8'h7E, 8'h00, 8'hFF, 8'h42, 8'h99};

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0, fon = 0, foff = 0, iow = 0, ior = 0, ack = 0, rstb = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdat = 0, iowd = 0, rxd = 0;
  logic [7:0] rdat, iord, txd;
  logic pend, rdy;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [2**MW];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_rom_overlay #(.ADDR_W(AW), .WIN_W(WW), .ROM_W(RW), .RAM_W(MW), .ROM_IMAGE(IMG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mem_req_i(req), .mem_we_i(we), .mem_addr_i(addr),
    .mem_wdata_i(wdat), .mem_rdata_o(rdat), .force_on_i(fon), .force_off_i(foff),
    .io_wr_i(iow), .io_rd_i(ior), .io_wdata_i(iowd), .io_rdata_o(iord),
    .prn_tx_data_o(txd), .prn_tx_pend_o(pend), .prn_tx_ack_i(ack),
    .prn_rx_data_i(rxd), .prn_rx_stb_i(rstb), .prn_rx_rdy_o(rdy));

  task automatic chk(string req_tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic mem_wr(int a, logic [7:0] d);
    req = 1; we = 1; addr = AW'(a); wdat = d; tick(); req = 0; we = 0;
    model[a] = d;
  endtask

  task automatic mem_rd(int a);
    req = 1; we = 0; addr = AW'(a); tick(); req = 0;
  endtask

  task automatic io_write(logic [7:0] d, logic f_on, logic f_off, logic a);
    iow = 1; iowd = d; fon = f_on; foff = f_off; ack = a; tick();
    iow = 0; fon = 0; foff = 0; ack = 0;
  endtask

  task automatic sweep(bit en, string tag_rom, string tag_ram);
    for (int a = 0; a < 2**AW; a++) begin
      mem_rd(a);
      if (en && a < 2**WW) chk(tag_rom, rdat, IMG[a % (2**RW)]);
      else chk(tag_ram, rdat, model[a]);
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 pend", pend, 0); chk("R1 rdy", rdy, 0);
    chk("R1 rdata", rdat, 0); chk("R1 iordata", iord, 0);
    mem_rd(0); chk("R1 overlay on", rdat, IMG[0]);

    for (int a = 0; a < 2**AW; a++) mem_wr(a, 8'((a * 37 + 5) & 255));
    sweep(1, "R2", "R3");

    io_write(8'h01, 0, 0, 0);
    chk("R6 pend", pend, 1); chk("R6 data", txd, 8'h01);
    sweep(0, "R4", "R4");

    io_write(8'hFE, 0, 0, 0);
    chk("R6 overwrite", txd, 8'hFE); chk("R6 pend", pend, 1);
    for (int a = 0; a < 2**WW; a++) begin
      mem_rd(a); chk("R5 re-enable", rdat, IMG[a % (2**RW)]);
    end

    // R5: switch takes effect on the read right after the port write
    io_write(8'h03, 0, 0, 0); mem_rd(2); chk("R5 disable", rdat, model[2]);
    io_write(8'h02, 0, 0, 0); mem_rd(2); chk("R5 enable", rdat, IMG[2]);

    ack = 1; tick(); ack = 0; chk("R7 ack", pend, 0);
    io_write(8'h44, 0, 0, 1); chk("R7 wr+ack", pend, 1); chk("R7 data", txd, 8'h44);
    ack = 1; tick(); ack = 0; chk("R7 ack2", pend, 0);

    mem_rd(9); chk("R10 read", rdat, IMG[1]);
    tick(); tick(); chk("R10 idle hold", rdat, IMG[1]);
    mem_wr(20, 8'hAB); chk("R10 write hold", rdat, IMG[1]);
    mem_wr(5, 8'h6D); chk("R4 hidden write held", rdat, IMG[1]);
    mem_rd(5); chk("R2 rom over write", rdat, IMG[5]);

    rxd = 8'h3C; rstb = 1; tick(); rstb = 0; chk("R8 rdy set", rdy, 1);
    ior = 1; tick(); ior = 0; chk("R8 read", iord, 8'h3C); chk("R8 rdy clr", rdy, 0);
    rxd = 8'h77; rstb = 1; tick(); rstb = 0;
    rxd = 8'h88; rstb = 1; ior = 1; tick(); rstb = 0; ior = 0;
    chk("R8 read old", iord, 8'h77); chk("R8 rdy kept", rdy, 1);
    ior = 1; tick(); ior = 0; chk("R8 read new", iord, 8'h88);

    io_write(8'h00, 0, 1, 0); mem_rd(5); chk("R9 force off", rdat, model[5]);
    io_write(8'h01, 1, 0, 0); mem_rd(5); chk("R9 force on", rdat, IMG[5]);
    io_write(8'h00, 1, 1, 0); mem_rd(5); chk("R9 off wins", rdat, model[5]);
    fon = 1; tick(); fon = 0; mem_rd(5); chk("R9 force on alone", rdat, IMG[5]);
    foff = 1; tick(); foff = 0;
    sweep(0, "R4", "R3");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule